// File: doc/BRIEF.md
# Overcurrent Fault Latch with Debounce

This block is the digital fault controller of a shunt-based phase current sensor. A comparator upstream flags when the magnitude of the shunt voltage is above the trip level, in either polarity. The block turns that flag into a latched, active-low fault drive. It only latches when the flag has stayed high without a break for longer than a debounce interval. While the fault is latched, the block also tells the PWM output driver to release its open-drain line.

The latch clears only when the shared PWM line is seen low for a minimum number of consecutive cycles. A supervisor can pull the line low to clear it. The fault pin can also be wired to the PWM pin, so that the fault's own pull-down clears the latch and the block resets itself. If the comparator flag is still high when a clear happens, the fault is latched again at the next SYNC transition, with no new debounce interval. All inputs are taken as synchronous to the system clock. Both intervals are parameters counted in system clock cycles.

Top module: `oc_fault_latch`

## Requirements
- R1: While reset is asserted and after it is released, `flt_n` is 1 (fault released) and `po_block` is 0, until a fault is qualified.
- R2: When `oc_flag` has been sampled high on DEB_CYC+1 consecutive clock edges, the latch sets on the last of those edges. From then on `flt_n` is 0 and `po_block` is 1. A run of DEB_CYC edges or fewer latches nothing, and a run of any length beyond DEB_CYC latches, because the debounce count saturates.
- R3: A single low sample of `oc_flag` before the interval completes restarts the debounce count from zero.
- R4: Once latched, the fault stays latched while `po_sense` is high. It also stays latched through a low stretch of `po_sense` (0 = line low) shorter than CLR_CYC consecutive edges.
- R5: The latch clears on the CLR_CYC-th consecutive clock edge at which `po_sense` is sampled 0, and `flt_n` returns to 1. CLR_CYC-1 low edges are not enough.
- R6: While latched, `po_block` is 1, so the PWM driver cannot pull the line low. When no fault is latched, `po_block` is 0 and the driver controls the line.
- R7: If `oc_flag` is still high at the clearing edge, the fault is not latched again by debounce. It is latched again at the first clock edge that sees `sync_in` differ from its value on the previous edge, whether that transition is rising or falling.
- R8: If `oc_flag` drops after such a clear, the pending re-latch is cancelled, and a new fault needs a full debounce run of DEB_CYC+1 high samples.
- R9: With `flt_n` wired-AND onto the PWM line and the overcurrent held, the fault holds the line low for exactly CLR_CYC cycles, clears itself, and is latched again at each following SYNC transition. Once the overcurrent goes away, the fault clears and stays released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | SYNC clock, sampled; either transition re-arms a pending fault |
| oc_flag | input | 1 | Digitised overcurrent comparator output, 1 = above threshold |
| po_sense | input | 1 | Sensed level of the shared PWM output line, 0 = line low |
| flt_n | output | 1 | Fault drive, active low (0 = pull fault pin low) |
| po_block | output | 1 | 1 forces the PWM output driver off |

## Verification
The bench sweeps comparator pulse lengths on both sides of the debounce boundary. A design that is off by one in its count latches on a pulse one cycle too short, or misses one that is just long enough. The bench breaks a nearly complete pulse with one low sample, which catches a counter that only pauses instead of restarting. It also holds the line low for one cycle less than the clear interval, which shows up a clear that fires early. After a clear with the overcurrent still present, the bench waits several debounce intervals with SYNC frozen and then toggles it in each direction. A design that re-latches by debounce, or that watches only one SYNC edge, fails here. The self-reset loop is measured cycle by cycle, so a wrong pulse width or a latch that never comes back is caught.

// File: rtl/oc_fault_latch.sv
module oc_fault_latch #(
  parameter int unsigned DEB_CYC = 470,
  parameter int unsigned CLR_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic oc_flag,
  input  logic po_sense,
  output logic flt_n,
  output logic po_block
);
  localparam int DW = $clog2(DEB_CYC + 1);
  localparam int CW = $clog2(CLR_CYC + 1);

  logic          latched;
  logic          pend;
  logic          sync_q;
  logic [DW-1:0] deb_cnt;
  logic [CW-1:0] clr_cnt;

  logic sync_edge, deb_full, clr_hit, fire, clear;

  assign sync_edge = sync_in ^ sync_q;
  assign deb_full  = (deb_cnt == DW'(DEB_CYC));
  assign clr_hit   = !po_sense && (clr_cnt == CW'(CLR_CYC - 1));
  assign fire      = !latched && oc_flag && ((deb_full && !pend) || (pend && sync_edge));
  assign clear     = latched && clr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb_cnt <= '0;
    end else if (!oc_flag || latched || pend) begin
      deb_cnt <= '0;
    end else if (!deb_full) begin
      deb_cnt <= deb_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_cnt <= '0;
    end else if (!latched || po_sense) begin
      clr_cnt <= '0;
    end else if (clr_cnt != CW'(CLR_CYC - 1)) begin
      clr_cnt <= clr_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (fire) begin
        latched <= 1'b1;
      end else if (clear) begin
        latched <= 1'b0;
      end
      if (clear) begin
        pend <= oc_flag;
      end else if (!oc_flag || fire) begin
        pend <= 1'b0;
      end
    end
  end

  assign flt_n    = ~latched;
  assign po_block = latched;
endmodule

// File: rtl/oc_fault_latch_chk.sv
module oc_fault_latch_chk #(
  parameter int unsigned DEB_CYC = 470
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           sync_in,
  input logic                           sync_q,
  input logic                           oc_flag,
  input logic                           po_sense,
  input logic                           flt_n,
  input logic                           po_block,
  input logic                           pend,
  input logic [$clog2(DEB_CYC+1)-1:0]   deb_cnt
);
  localparam int DW = $clog2(DEB_CYC + 1);

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (flt_n && !po_block));

  p_set_needs_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_n) |-> $past(oc_flag));

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_flag |=> (deb_cnt == '0));

  p_deb_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    deb_cnt <= DW'(DEB_CYC));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_n && po_sense) |=> !flt_n);

  p_clear_by_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_n) |-> !$past(po_sense));

  p_rearm_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && flt_n && (sync_in == sync_q)) |=> flt_n);

  p_rearm_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && flt_n && oc_flag && (sync_in != sync_q)) |=> !flt_n);
endmodule

bind oc_fault_latch oc_fault_latch_chk #(.DEB_CYC(DEB_CYC)) chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_q(sync_q),
  .oc_flag(oc_flag), .po_sense(po_sense), .flt_n(flt_n),
  .po_block(po_block), .pend(pend), .deb_cnt(deb_cnt)
);

// File: tb/oc_fault_latch_test.sv
module oc_fault_latch_test;
  localparam int D = 10;
  localparam int C = 5;
  localparam int P = 16;
  localparam int NV = 8;
  localparam int VLEN [NV] = '{1, 3, D-2, D-1, D, D+1, D+2, 4*D};
  localparam int VEXP [NV] = '{0, 0, 0, 0, 0, 1, 1, 1};

  logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0, oc_flag = 1'b0;
  logic pwm_n = 1'b1, ext_n = 1'b1, tie = 1'b0;
  logic flt_n, po_block, po_line;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  assign po_line = (po_block | pwm_n) & ext_n & (tie ? flt_n : 1'b1);

  oc_fault_latch #(.DEB_CYC(D), .CLR_CYC(C)) uut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .oc_flag(oc_flag),
    .po_sense(po_line), .flt_n(flt_n), .po_block(po_block)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_fault;
    ext_n = 1'b0;
    step(C);
    ext_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 flt_n in reset", flt_n, 1);
    chk("R1 po_block in reset", po_block, 0);
    rst_n = 1'b1;
    step(3);
    chk("R1 flt_n after reset", flt_n, 1);
    chk("R1 po_block after reset", po_block, 0);

    // R2: pulse-length sweep around the debounce boundary
    for (int i = 0; i < NV; i++) begin
      oc_flag = 1'b1;
      step(VLEN[i]);
      oc_flag = 1'b0;
      chk($sformatf("R2 flt_n len %0d", VLEN[i]), flt_n, VEXP[i] ? 0 : 1);
      chk($sformatf("R2 po_block len %0d", VLEN[i]), po_block, VEXP[i]);
      if (VEXP[i] != 0) clear_fault();
      step(2);
    end

    // R3: one low sample restarts the count
    oc_flag = 1'b1; step(D);
    oc_flag = 1'b0; step(1);
    oc_flag = 1'b1; step(D);
    chk("R3 broken run no latch", flt_n, 1);
    step(1);
    chk("R3 fresh full run latches", flt_n, 0);
    oc_flag = 1'b0;

    // R4 / R5: hold and clear interval
    ext_n = 1'b0; step(C-1); ext_n = 1'b1; step(1);
    chk("R4 short low keeps latch", flt_n, 0);
    step(20);
    chk("R4 high line keeps latch", flt_n, 0);
    ext_n = 1'b0; step(C-1);
    chk("R5 C-1 low not cleared", flt_n, 0);
    step(1);
    chk("R5 C low cleared", flt_n, 1);
    ext_n = 1'b1;
    step(2);

    // R6: driver blocked while latched
    oc_flag = 1'b1; step(D+1); oc_flag = 1'b0;
    pwm_n = 1'b0; #1;
    chk("R6 po_block latched", po_block, 1);
    chk("R6 line released", po_line, 1);
    step(C+3);
    chk("R6 still latched with driver low", flt_n, 0);
    pwm_n = 1'b1;
    clear_fault();
    pwm_n = 1'b0; #1;
    chk("R6 driver controls line", po_line, 0);
    chk("R6 po_block clear", po_block, 0);
    pwm_n = 1'b1;
    step(2);

    // R7: re-latch on SYNC edges only
    oc_flag = 1'b1; step(D+1);
    chk("R7 initial latch", flt_n, 0);
    clear_fault();
    chk("R7 cleared under overcurrent", flt_n, 1);
    step(3*D);
    chk("R7 no relatch without SYNC edge", flt_n, 1);
    sync_in = 1'b1; step(1);
    chk("R7 relatch on rising SYNC", flt_n, 0);
    clear_fault();
    chk("R7 cleared again", flt_n, 1);
    step(5);
    chk("R7 waits again", flt_n, 1);
    sync_in = 1'b0; step(1);
    chk("R7 relatch on falling SYNC", flt_n, 0);

    // R8: flag drop cancels the pending re-latch
    clear_fault();
    oc_flag = 1'b0; step(1);
    oc_flag = 1'b1; sync_in = 1'b1; step(1);
    chk("R8 SYNC edge after drop no latch", flt_n, 1);
    step(D-1);
    chk("R8 D samples no latch", flt_n, 1);
    step(1);
    chk("R8 D+1 samples latch", flt_n, 0);
    oc_flag = 1'b0;
    clear_fault();
    step(2);

    // R9: fault pin tied to the PWM line
    begin
      int eps = 0, run = 0, bad = 0;
      tie = 1'b1;
      oc_flag = 1'b1;
      for (int i = 0; i < P*10; i++) begin
        if (i % P == P-1) sync_in = ~sync_in;
        step(1);
        if (flt_n == 1'b0) begin
          run++;
        end else if (run != 0) begin
          eps++;
          if (run != C) bad++;
          chk("R9 self-reset low width", run, C);
          run = 0;
        end
      end
      chk("R9 repeated self-reset", (eps >= 3) ? 1 : 0, 1);
      chk("R9 all widths exact", bad, 0);
      oc_flag = 1'b0;
      step(C + 2*P);
      chk("R9 released after overcurrent ends", flt_n, 1);
      tie = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule